// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router collects the level-sensitive INTA to INTD pins of up to 32 device slots and folds them onto eight shared interrupt request lines, PIRQ A to H. Each slot has a programmable routing word that chooses, for every one of its four pins, which PIRQ the pin feeds. One slot is fixed: its routing word always reads as zero, and its four pins always go to PIRQ E, F, G and H in order.

Two output groups are driven from the PIRQ levels in parallel. The legacy group, outputs 0 to 15, is steered by eight route bytes. Each route byte carries a target line number and a disable flag. The APIC group, outputs 16 to 23, follows PIRQ A to H one to one and ignores the route bytes. A power-management SCI input is also merged, by OR, onto one output chosen by a small select field. The whole 24-bit vector is registered and is rebuilt every clock from the current pins and register contents. A change to the SCI select therefore moves the SCI from its old line to its new line in a single step.

Software reaches the routing state through a plain write port (enable, address, data) and a combinational read port. The block has no state machine. Its only sequential state is the configuration registers and the output register.

Top module: `pci_irq_router`

## Requirements
- R1: After reset every route byte reads 0x0080 (disabled, line 0), the SCI select reads 0, and every slot routing word holds its default. The default sends pin x of slot s to PIRQ ((s+x) mod 4)+4. In the word, pin x owns nibble x (bits 4x+3..4x), the PIRQ index sits in the low three bits of that nibble, and the top bit reads 0. During reset and in the first cycle after it, irq_out is 0.
- R2: A write to address s (0 to 31, except 30) sets slot s's routing word, and its pins then feed the PIRQs named by its nibbles. Pin x of slot s is int_pins[4s+x].
- R3: Writes to address 30 are ignored and that word reads 0. Slot 30's pin x always drives PIRQ E+x.
- R4: irq_out[16+n] is the level of PIRQ n, whatever route byte n holds (plus the SCI when it targets that line).
- R5: irq_out[k] for k in 0..15 is the OR of every PIRQ whose route byte has bit 7 clear and bits 4..0 equal to k (plus the SCI when it targets k).
- R6: A PIRQ whose route byte has bit 7 set, or whose bits 4..0 hold 16 or more, adds nothing to irq_out[15:0].
- R7: The route bytes of PIRQ A..D are at addresses 0x40..0x43 and those of PIRQ E..H at 0x48..0x4B. Writes use wr_data[7:0], and reads return the byte zero-extended.
- R8: The SCI select is wr_data[2:0] at address 0x50. Codes 0, 1, 2, 4 and 5 put sci_in onto irq_out line 9, 10, 11, 20 and 21. Codes 3, 6 and 7 route it nowhere.
- R9: If the SCI select changes while sci_in is high, the old line drops and the new line rises in the same cycle, unless other sources hold them.
- R10: Every output is registered. A change at the pins, at sci_in, or a register write is seen on irq_out one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_pins | input | 128 | Pin levels, bit 4*slot+pin |
| sci_in | input | 1 | SCI level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| irq_out | output | 24 | Registered interrupt lines: 0..15 legacy, 16..23 APIC |

## Verification
The pins are driven first with every route disabled. This separates the unconditional APIC path from the route-steered legacy path. With several PIRQs sharing one legacy line, random pin patterns show whether the OR-merge is correct. A route byte with an out-of-range line number, and the fixed slot, show whether those routes are really dropped or hard-wired. The SCI select is then stepped through all eight codes while sci_in is held high. This tells a correct move between lines apart from a lingering old line or a one-cycle gap.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    localparam int ADDR_W        = 7;
    localparam int DATA_W        = 16;
    localparam int ROUTE_W       = 8;
    localparam int ROUTE_DIS_BIT = 7;
    localparam int ROUTE_IRQ_W   = 5;
    localparam int SCI_SEL_W     = 3;
    localparam int LINE_W        = 5;

    localparam logic [ADDR_W-1:0]  ROUTE_LO_BASE  = 7'h40;
    localparam logic [ADDR_W-1:0]  ROUTE_HI_BASE  = 7'h48;
    localparam logic [ADDR_W-1:0]  ACPI_CTRL_ADDR = 7'h50;
    localparam logic [ROUTE_W-1:0] ROUTE_RESET    = 8'h80;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } sci_target_t;

    function automatic sci_target_t sci_decode(input logic [SCI_SEL_W-1:0] sel);
        sci_target_t t;
        t.valid = 1'b1;
        case (sel)
            3'd0:    t.line = 5'd9;
            3'd1:    t.line = 5'd10;
            3'd2:    t.line = 5'd11;
            3'd4:    t.line = 5'd20;
            3'd5:    t.line = 5'd21;
            default: begin
                t.valid = 1'b0;
                t.line  = 5'd0;
            end
        endcase
        return t;
    endfunction
endpackage

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int NUM_PINS   = 4,
    parameter int NUM_PIRQ   = 8,
    parameter int FIELD_W    = 4,
    parameter int FIXED_SLOT = 30
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_SLOTS*NUM_PINS-1:0]  pins,
    output logic [NUM_SLOTS*NUM_PINS*FIELD_W-1:0] rd_words,
    output logic [NUM_PIRQ-1:0]            pirq_lvl
);
    localparam int PIDX_W = $clog2(NUM_PIRQ);
    localparam int HALF   = NUM_PIRQ / 2;
    localparam int NUM_IN = NUM_SLOTS * NUM_PINS;
    localparam int WORD_W = NUM_PINS * FIELD_W;

    logic [NUM_IN*PIDX_W-1:0] map_flat;
    logic                     unused_wr;
    assign unused_wr = ^wr_data;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            for (genvar x = 0; x < NUM_PINS; x++) begin : g_pin
                localparam int LANE = s * NUM_PINS + x;
                if (s == FIXED_SLOT) begin : g_fixed
                    assign map_flat[LANE*PIDX_W +: PIDX_W] = PIDX_W'(x + HALF);
                    assign rd_words[s*WORD_W + x*FIELD_W +: FIELD_W] = '0;
                end else begin : g_prog
                    localparam logic [PIDX_W-1:0] DEFV = PIDX_W'(((s + x) % HALF) + HALF);
                    logic [PIDX_W-1:0] fld_q;
                    always_ff @(posedge clk) begin
                        if (rst)
                            fld_q <= DEFV;
                        else if (wr_en && wr_addr == ADDR_W'(s))
                            fld_q <= wr_data[x*FIELD_W +: PIDX_W];
                    end
                    assign map_flat[LANE*PIDX_W +: PIDX_W] = fld_q;
                    assign rd_words[s*WORD_W + x*FIELD_W +: FIELD_W] = FIELD_W'(fld_q);
                end
            end
        end
    endgenerate

    always_comb begin
        pirq_lvl = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (pins[i])
                pirq_lvl[map_flat[i*PIDX_W +: PIDX_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int GROUP    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_PIRQ*ROUTE_W-1:0] route_flat,
    output logic [SCI_SEL_W-1:0]        sci_sel
);
    function automatic logic [ADDR_W-1:0] route_addr(input int p);
        if (p < GROUP)
            return ROUTE_LO_BASE + ADDR_W'(p);
        return ROUTE_HI_BASE + ADDR_W'(p - GROUP);
    endfunction

    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:ROUTE_W];

    generate
        for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
            logic [ROUTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= ROUTE_RESET;
                else if (wr_en && wr_addr == route_addr(p))
                    byte_q <= wr_data[ROUTE_W-1:0];
            end
            assign route_flat[p*ROUTE_W +: ROUTE_W] = byte_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            sci_sel <= '0;
        else if (wr_en && wr_addr == ACPI_CTRL_ADDR)
            sci_sel <= wr_data[SCI_SEL_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (rd_addr == route_addr(p))
                rd_data = DATA_W'(route_flat[p*ROUTE_W +: ROUTE_W]);
        end
        if (rd_addr == ACPI_CTRL_ADDR)
            rd_data = DATA_W'(sci_sel);
    end
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PIRQ-1:0]         pirq_lvl,
    input  logic [NUM_PIRQ*ROUTE_W-1:0] route_flat,
    input  logic                        sci_in,
    input  logic [SCI_SEL_W-1:0]        sci_sel,
    output logic [NUM_LEGACY+NUM_PIRQ-1:0] irq_out
);
    localparam int NUM_OUT = NUM_LEGACY + NUM_PIRQ;
    localparam int GAP_W   = ROUTE_DIS_BIT - ROUTE_IRQ_W;

    sci_target_t             tgt;
    logic [NUM_OUT-1:0]      out_d;
    logic [NUM_PIRQ*GAP_W-1:0] unused_route;

    assign tgt = sci_decode(sci_sel);

    generate
        for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_gap
            assign unused_route[p*GAP_W +: GAP_W] = route_flat[p*ROUTE_W + ROUTE_IRQ_W +: GAP_W];
        end
    endgenerate

    always_comb begin
        out_d = '0;
        for (int k = 0; k < NUM_LEGACY; k++) begin
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if (!route_flat[p*ROUTE_W + ROUTE_DIS_BIT] &&
                    route_flat[p*ROUTE_W +: ROUTE_IRQ_W] == ROUTE_IRQ_W'(k) &&
                    pirq_lvl[p])
                    out_d[k] = 1'b1;
            end
        end
        for (int p = 0; p < NUM_PIRQ; p++)
            out_d[NUM_LEGACY + p] = pirq_lvl[p];
        if (sci_in && tgt.valid && int'(tgt.line) < NUM_OUT)
            out_d[tgt.line] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= '0;
        else
            irq_out <= out_d;
    end

    // checker state: the SCI target seen one clock earlier
    logic              sci_on_d;
    logic [LINE_W-1:0] sci_line_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            sci_on_d   <= 1'b0;
            sci_line_d <= '0;
        end else begin
            sci_on_d   <= sci_in && tgt.valid && int'(tgt.line) < NUM_OUT;
            sci_line_d <= tgt.line;
        end
    end

    assert_sci_lands_R8: assert property (@(posedge clk) disable iff (rst)
        sci_on_d |-> irq_out[sci_line_d]);

    generate
        for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_apic_chk
            assert_apic_follow_R4: assert property (@(posedge clk) disable iff (rst)
                !(sci_in && tgt.valid && tgt.line == LINE_W'(NUM_LEGACY + p))
                |=> irq_out[NUM_LEGACY + p] == $past(pirq_lvl[p]));
        end
    endgenerate
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int NUM_PINS   = 4,
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    parameter int FIELD_W    = 4,
    parameter int FIXED_SLOT = 30
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SLOTS*NUM_PINS-1:0] int_pins,
    input  logic                          sci_in,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_LEGACY+NUM_PIRQ-1:0] irq_out
);
    localparam int WORD_W = NUM_PINS * FIELD_W;

    logic [NUM_SLOTS*WORD_W-1:0]   slot_words;
    logic [NUM_PIRQ-1:0]           pirq_lvl;
    logic [NUM_PIRQ*ROUTE_W-1:0]   route_flat;
    logic [SCI_SEL_W-1:0]          sci_sel;
    logic [DATA_W-1:0]             route_rd;

    pirq_slot_map #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS), .NUM_PIRQ(NUM_PIRQ),
        .FIELD_W(FIELD_W), .FIXED_SLOT(FIXED_SLOT)
    ) slot_map_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pins(int_pins), .rd_words(slot_words), .pirq_lvl(pirq_lvl)
    );

    pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .GROUP(NUM_PIRQ/2)) route_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(route_rd), .route_flat(route_flat), .sci_sel(sci_sel)
    );

    pirq_irq_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) merge_i (
        .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl), .route_flat(route_flat),
        .sci_in(sci_in), .sci_sel(sci_sel), .irq_out(irq_out)
    );

    always_comb begin
        rd_data = route_rd;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_addr == ADDR_W'(s))
                rd_data = DATA_W'(slot_words[s*WORD_W +: WORD_W]);
        end
    end

    // checker state: any legacy-capable route or legacy SCI one clock earlier
    sci_target_t sci_t;
    logic        any_leg_d;
    logic        sci_leg_d;
    assign sci_t = sci_decode(sci_sel);
    always_ff @(posedge clk) begin
        if (rst) begin
            any_leg_d <= 1'b0;
            sci_leg_d <= 1'b0;
        end else begin
            any_leg_d <= 1'b0;
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if (!route_flat[p*ROUTE_W + ROUTE_DIS_BIT] &&
                    int'(route_flat[p*ROUTE_W +: ROUTE_IRQ_W]) < NUM_LEGACY)
                    any_leg_d <= 1'b1;
            end
            sci_leg_d <= sci_in && sci_t.valid && int'(sci_t.line) < NUM_LEGACY;
        end
    end

    assert_legacy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !any_leg_d && !sci_leg_d |-> irq_out[NUM_LEGACY-1:0] == '0);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_out == '0);

    assert_fixed_slot_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_addr == ADDR_W'(FIXED_SLOT) |-> rd_data == '0);
endmodule

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] int_pins = '0;
    logic         sci_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [6:0]   wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [6:0]   rd_addr = '0;
    logic [15:0]  rd_data;
    logic [23:0]  irq_out;

    always #2.5 clk = ~clk;

    pci_irq_router dut_i (
        .clk(clk), .rst(rst), .int_pins(int_pins), .sci_in(sci_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    int          tests = 0;
    int          fails = 0;
    int          cycles = 0;
    bit          started = 0;
    string       cur_req = "R1";

    // reference model state
    int          smap [0:31][0:3];
    logic [7:0]  rb [0:7];
    logic [2:0]  msel;
    logic [23:0] exp_out;

    function automatic logic [23:0] model_out();
        logic [7:0]  pl;
        logic [23:0] o;
        int          t;
        pl = '0;
        for (int s = 0; s < 32; s++)
            for (int x = 0; x < 4; x++)
                if (int_pins[s*4+x]) pl[(s == 30) ? (4 + x) : smap[s][x]] = 1'b1;
        o = '0;
        for (int p = 0; p < 8; p++) begin
            o[16+p] = pl[p];
            if (!rb[p][7] && rb[p][4:0] < 5'd16 && pl[p]) o[rb[p][3:0]] = 1'b1;
        end
        case (msel)
            3'd0: t = 9;
            3'd1: t = 10;
            3'd2: t = 11;
            3'd4: t = 20;
            3'd5: t = 21;
            default: t = -1;
        endcase
        if (sci_in && t >= 0) o[t] = 1'b1;
        return o;
    endfunction

    function automatic logic [15:0] model_read(input logic [6:0] a);
        logic [15:0] v;
        v = '0;
        if (a < 7'd32) begin
            if (a != 7'd30)
                for (int x = 0; x < 4; x++) v[x*4 +: 4] = 4'(smap[a][x]);
        end else if (a >= 7'h40 && a <= 7'h43) v = {8'h00, rb[a - 7'h40]};
        else if (a >= 7'h48 && a <= 7'h4B) v = {8'h00, rb[a - 7'h48 + 4]};
        else if (a == 7'h50) v = {13'd0, msel};
        return v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 32; s++)
            for (int x = 0; x < 4; x++) smap[s][x] = ((s + x) % 4) + 4;
        for (int p = 0; p < 8; p++) rb[p] = 8'h80;
        msel = 3'd0;
    endtask

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            model_reset();
            exp_out = '0;
        end else begin
            exp_out = model_out();
            if (wr_en) begin
                if (wr_addr < 7'd32 && wr_addr != 7'd30)
                    for (int x = 0; x < 4; x++) smap[wr_addr][x] = int'(wr_data[x*4 +: 3]);
                else if (wr_addr >= 7'h40 && wr_addr <= 7'h43) rb[wr_addr - 7'h40] = wr_data[7:0];
                else if (wr_addr >= 7'h48 && wr_addr <= 7'h4B) rb[wr_addr - 7'h48 + 4] = wr_data[7:0];
                else if (wr_addr == 7'h50) msel = wr_data[2:0];
            end
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // every-cycle comparison against the model (R10 timing built in)
    always @(negedge clk) begin
        if (started) begin
            tests++;
            if (irq_out !== exp_out) begin
                fails++;
                $display("FAIL %s cycle %0d: irq_out=%h expected %h", cur_req, cycles, irq_out, exp_out);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input logic [6:0] a, input string tag);
        rd_addr = a;
        #1;
        tests++;
        if (rd_data !== model_read(a)) begin
            fails++;
            $display("FAIL %s read @%h: rd_data=%h expected %h", tag, a, rd_data, model_read(a));
        end
    endtask

    task automatic bitchk(input int idx, input logic v, input string tag);
        tests++;
        if (irq_out[idx] !== v) begin
            fails++;
            $display("FAIL %s irq_out[%0d]: actual %b expected %b", tag, idx, irq_out[idx], v);
        end
    endtask

    task automatic rand_pins(input int n);
        for (int i = 0; i < n; i++) begin
            int_pins = {$urandom, $urandom, $urandom, $urandom} & {4{$urandom}};
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        bitchk(9, 1'b0, "R1");
        rdchk(7'd0, "R1"); rdchk(7'd1, "R1"); rdchk(7'd31, "R1");
        rdchk(7'h40, "R1"); rdchk(7'h4B, "R1"); rdchk(7'h50, "R1");
        rdchk(7'd30, "R3");

        cur_req = "R4";
        int_pins = '0; int_pins[0] = 1'b1;          // slot 0 INTA -> PIRQ E
        @(negedge clk);
        bitchk(20, 1'b1, "R4");
        bitchk(11, 1'b0, "R6");
        rand_pins(20);

        cur_req = "R7";
        wr(7'h40, 16'h0003); wr(7'h41, 16'h000B);
        wr(7'h48, 16'h000B); wr(7'h49, 16'h000B);
        wr(7'h4A, 16'h0005); wr(7'h4B, 16'h0085);
        rdchk(7'h40, "R7"); rdchk(7'h41, "R7"); rdchk(7'h48, "R7"); rdchk(7'h4B, "R7");

        cur_req = "R5";
        int_pins = '0; int_pins[0] = 1'b1;
        @(negedge clk);
        bitchk(11, 1'b1, "R5");
        rand_pins(40);

        cur_req = "R6";
        wr(7'h48, 16'h0010); wr(7'h49, 16'h008B);
        int_pins = '0; int_pins[0] = 1'b1; int_pins[1] = 1'b1;  // PIRQ E, F
        @(negedge clk); @(negedge clk);
        bitchk(11, 1'b0, "R6");
        bitchk(20, 1'b1, "R4");
        bitchk(21, 1'b1, "R4");
        rand_pins(20);

        cur_req = "R2";
        wr(7'd2, 16'h0000);
        rdchk(7'd2, "R2");
        int_pins = '0; int_pins[2*4+2] = 1'b1;      // slot 2 INTC -> PIRQ A
        @(negedge clk);
        bitchk(3, 1'b1, "R2");
        bitchk(16, 1'b1, "R2");
        rand_pins(20);

        cur_req = "R3";
        wr(7'd30, 16'h3210);
        rdchk(7'd30, "R3");
        int_pins = '0; int_pins[30*4] = 1'b1;       // slot 30 INTA -> PIRQ E
        @(negedge clk);
        bitchk(20, 1'b1, "R3");
        bitchk(16, 1'b0, "R3");

        cur_req = "R10";
        int_pins = '0; int_pins[2*4] = 1'b1;        // PIRQ A, line 3
        @(negedge clk);
        wr(7'h40, 16'h0007);
        bitchk(3, 1'b1, "R10");
        bitchk(7, 1'b0, "R10");
        @(negedge clk);
        bitchk(3, 1'b0, "R10");
        bitchk(7, 1'b1, "R10");

        cur_req = "R8";
        int_pins = '0; sci_in = 1'b1;
        @(negedge clk);
        bitchk(9, 1'b1, "R8");
        for (int c = 1; c < 8; c++) begin
            wr(7'h50, 16'(c));
            @(negedge clk);
            if (c == 4) bitchk(20, 1'b1, "R8");
            if (c == 3) begin tests++; if (irq_out !== '0) begin fails++;
                $display("FAIL R8 code 3: irq_out=%h expected 000000", irq_out); end end
        end

        cur_req = "R9";
        wr(7'h50, 16'h0000);
        @(negedge clk);
        wr(7'h50, 16'h0005);
        bitchk(9, 1'b1, "R9"); bitchk(21, 1'b0, "R9");
        @(negedge clk);
        bitchk(9, 1'b0, "R9"); bitchk(21, 1'b1, "R9");

        cur_req = "R5";
        for (int i = 0; i < 60; i++) begin
            sci_in = 1'($urandom);
            if (i % 15 == 0) wr(7'h50, 16'($urandom % 8));
            int_pins = {$urandom, $urandom, $urandom, $urandom} & {4{$urandom}};
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule